// File: doc/BRIEF.md
# Operand Address Generator

This block forms the memory operand address for a 32-bit processor with many addressing modes. A request presents the mode, the operand size, the base address register and its index, an index register value and the address of the opcode word. Any extension words that the mode needs then arrive one per cycle on a separate strobe. One cycle after the last word is taken, the block presents the address with a valid pulse. For the post-increment and pre-decrement modes it also presents the new base register value and a write enable in that same cycle. It reports how many extension words the address consumed.

The request fields are captured on the start cycle, so the caller may change them afterwards. A new start is accepted only when no word gathering is in progress. An accepted start may fall in the cycle that presents the previous result. A request with an unsupported mode code gives an illegal pulse and produces no address.

Top module: `ea_unit`

## Requirements
- R1: A synchronous reset drives `ea_valid`, `illegal` and `wb_en` low and abandons any partly gathered request. A request started after reset behaves as if none had preceded it.
- R2: Mode 0 (register indirect) needs no extension word. `ea` equals the base register, `ext_cnt` is 0 and `wb_en` stays low. `ea_valid` rises in the cycle after the accepted start.
- R3: Mode 1 (post-increment) presents the unmodified base as `ea` and presents `wb_val` = base + step with `wb_en` high. The step is 1, 2 or 4 for size codes 0, 1 or 2, and size code 3 steps by 4.
- R4: Mode 2 (pre-decrement) presents base − step as both `ea` and `wb_val`, with `wb_en` high.
- R5: When `areg_idx` is 7 (the stack pointer) and the size code is 0, the step in modes 1 and 2 is 2 instead of 1.
- R6: Mode 3 takes one extension word. `ea` = base + that word sign-extended from 16 bits.
- R7: Mode 4 takes one extension word. `ea` = base + bits 7:0 of the word sign-extended + `xreg`. Bits 15:8 have no effect.
- R8: Mode 5 takes one word and `ea` is that word sign-extended. Mode 6 takes two words: the first received gives `ea[31:16]` and the second gives `ea[15:0]`. `ext_cnt` reports 1 or 2 respectively.
- R9: Modes 7 and 8 compute like modes 3 and 4 with the base replaced by `pc` + 2, the address of the extension word that follows the opcode word at `pc`.
- R10: With mode needing words, `ea_valid` rises in the cycle after the final word is accepted, whatever idle gaps separate the words. `ext_valid` while no request is gathering is ignored. A `start` while gathering is ignored.
- R11: Mode codes 9 to 15 give a one-cycle `illegal` pulse in the cycle after start, with `ea_valid` and `wb_en` low and `ext_cnt` 0.
- R12: All address sums and differences wrap modulo 2^32.
- R13: `wb_en` is never high unless `ea_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a request; fields below are captured |
| mode | input | 4 | Addressing mode code |
| size | input | 2 | Operand size code: 0 byte, 1 word, 2 or 3 long |
| areg | input | 32 | Base address register value |
| areg_idx | input | 3 | Base address register number |
| xreg | input | 32 | Index register value |
| pc | input | 32 | Address of the opcode word |
| ext_valid | input | 1 | Extension word present this cycle |
| ext_word | input | 16 | Extension word |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | One-cycle pulse: `ea` is ready |
| illegal | output | 1 | One-cycle pulse: unsupported mode code |
| wb_en | output | 1 | Base register update enable |
| wb_val | output | 32 | New base register value |
| ext_cnt | output | 2 | Extension words consumed by this address |

## Verification
The result of one request and the acceptance of the next can fall in the same cycle. Likewise, a result and its register writeback always share a cycle. The bench provokes the first overlap by raising `start` exactly in the cycle where `ea_valid` is shown, both in directed runs and at random. It judges the overlap by checking that the second request produces its own correct address, count and writeback, not a mix of the two. Stray starts during word gathering and stray words while idle are injected and must leave the pending result unchanged.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        EAM_IND    = 4'd0,
        EAM_PINC   = 4'd1,
        EAM_PDEC   = 4'd2,
        EAM_DISP   = 4'd3,
        EAM_INDEX  = 4'd4,
        EAM_ABSW   = 4'd5,
        EAM_ABSL   = 4'd6,
        EAM_PCDISP = 4'd7,
        EAM_PCIDX  = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        OSZ_BYTE = 2'd0,
        OSZ_WORD = 2'd1,
        OSZ_LONG = 2'd2,
        OSZ_ALT  = 2'd3
    } op_size_e;

    // extension words a mode needs
    function automatic logic [1:0] ea_words(input logic [3:0] m);
        case (ea_mode_e'(m))
            EAM_DISP, EAM_INDEX, EAM_ABSW, EAM_PCDISP, EAM_PCIDX: ea_words = 2'd1;
            EAM_ABSL: ea_words = 2'd2;
            default:  ea_words = 2'd0;
        endcase
    endfunction

    function automatic logic ea_legal(input logic [3:0] m);
        ea_legal = (m <= 4'(EAM_PCIDX));
    endfunction

endpackage

// File: rtl/ea_step_calc.sv
module ea_step_calc #(
    parameter int AW     = 32,
    parameter int RIW    = 3,
    parameter int SP_IDX = 7
) (
    input  logic [1:0]     size,
    input  logic [RIW-1:0] idx,
    output logic [AW-1:0]  step
);
    import ea_pkg::*;

    logic is_sp;

    always_comb begin
        is_sp = (idx == RIW'(SP_IDX));
        case (op_size_e'(size))
            OSZ_BYTE: step = is_sp ? AW'(2) : AW'(1);
            OSZ_WORD: step = AW'(2);
            default:  step = AW'(4);
        endcase
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
    parameter int AW = 32,
    parameter int XW = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] xreg,
    input  logic [AW-1:0] pc,
    input  logic [XW-1:0] w0,
    input  logic [XW-1:0] w1,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    import ea_pkg::*;

    localparam int D8W = 8;
    localparam int PC_EXT_OFS = XW / 8;   // bytes in one opcode word

    logic [AW-1:0] disp16, disp8, pc_base, abs_long;

    always_comb begin
        disp16   = {{(AW-XW){w0[XW-1]}}, w0};
        disp8    = {{(AW-D8W){w0[D8W-1]}}, w0[D8W-1:0]};
        pc_base  = pc + AW'(PC_EXT_OFS);
        abs_long = AW'({w0, w1});
        wb_en    = 1'b0;
        wb_val   = base;
        case (ea_mode_e'(mode))
            EAM_IND:    ea = base;
            EAM_PINC: begin
                ea     = base;
                wb_en  = 1'b1;
                wb_val = base + step;
            end
            EAM_PDEC: begin
                ea     = base - step;
                wb_en  = 1'b1;
                wb_val = base - step;
            end
            EAM_DISP:   ea = base + disp16;
            EAM_INDEX:  ea = base + disp8 + xreg;
            EAM_ABSW:   ea = disp16;
            EAM_ABSL:   ea = abs_long;
            EAM_PCDISP: ea = pc_base + disp16;
            EAM_PCIDX:  ea = pc_base + disp8 + xreg;
            default:    ea = base;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int AW     = 32,
    parameter int XW     = 16,
    parameter int RIW    = 3,
    parameter int SP_IDX = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [1:0]     size,
    input  logic [AW-1:0]  areg,
    input  logic [RIW-1:0] areg_idx,
    input  logic [AW-1:0]  xreg,
    input  logic [AW-1:0]  pc,
    input  logic           ext_valid,
    input  logic [XW-1:0]  ext_word,
    output logic [AW-1:0]  ea,
    output logic           ea_valid,
    output logic           illegal,
    output logic           wb_en,
    output logic [AW-1:0]  wb_val,
    output logic [1:0]     ext_cnt
);
    import ea_pkg::*;

    typedef struct packed {
        logic           busy;
        logic [3:0]     mode;
        logic [1:0]     size;
        logic [AW-1:0]  base;
        logic [RIW-1:0] idx;
        logic [AW-1:0]  xreg;
        logic [AW-1:0]  pc;
        logic [1:0]     need;
        logic [1:0]     got;
        logic [XW-1:0]  w0;
        logic [AW-1:0]  ea;
        logic           valid;
        logic           illegal;
        logic           wb_en;
        logic [AW-1:0]  wb_val;
        logic [1:0]     cnt;
    } st_t;

    st_t st_d, st_q;

    logic           acc, take, fire;
    logic [3:0]     c_mode;
    logic [1:0]     c_size, c_need;
    logic [AW-1:0]  c_base, c_xreg, c_pc, c_step;
    logic [RIW-1:0] c_idx;
    logic [XW-1:0]  c_w0;
    logic [AW-1:0]  calc_ea, calc_wb_val;
    logic           calc_wb_en;

    // operand view: fresh request fields on an accepted start, held ones otherwise
    always_comb begin
        acc    = start && !st_q.busy;
        take   = st_q.busy && ext_valid;
        c_mode = acc ? mode     : st_q.mode;
        c_size = acc ? size     : st_q.size;
        c_base = acc ? areg     : st_q.base;
        c_idx  = acc ? areg_idx : st_q.idx;
        c_xreg = acc ? xreg     : st_q.xreg;
        c_pc   = acc ? pc       : st_q.pc;
        c_need = ea_words(c_mode);
        c_w0   = (st_q.got == 2'd0) ? ext_word : st_q.w0;
    end

    ea_step_calc #(.AW(AW), .RIW(RIW), .SP_IDX(SP_IDX)) step_i (
        .size (c_size),
        .idx  (c_idx),
        .step (c_step)
    );

    ea_addr_calc #(.AW(AW), .XW(XW)) addr_i (
        .mode   (c_mode),
        .base   (c_base),
        .xreg   (c_xreg),
        .pc     (c_pc),
        .w0     (c_w0),
        .w1     (ext_word),
        .step   (c_step),
        .ea     (calc_ea),
        .wb_en  (calc_wb_en),
        .wb_val (calc_wb_val)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        st_d.wb_en   = 1'b0;
        fire = (acc && ea_legal(mode) && (c_need == 2'd0))
            || (take && ((st_q.got + 2'd1) == st_q.need));

        if (acc) begin
            st_d.mode = mode;
            st_d.size = size;
            st_d.base = areg;
            st_d.idx  = areg_idx;
            st_d.xreg = xreg;
            st_d.pc   = pc;
            st_d.need = c_need;
            st_d.got  = 2'd0;
            if (!ea_legal(mode)) begin
                st_d.illegal = 1'b1;
                st_d.cnt     = 2'd0;
            end else if (c_need != 2'd0) begin
                st_d.busy = 1'b1;
            end
        end

        if (take) begin
            if (st_q.got == 2'd0) st_d.w0 = ext_word;
            st_d.got = st_q.got + 2'd1;
            if (fire) st_d.busy = 1'b0;
        end

        if (fire) begin
            st_d.ea     = calc_ea;
            st_d.valid  = 1'b1;
            st_d.wb_en  = calc_wb_en;
            st_d.wb_val = calc_wb_val;
            st_d.cnt    = c_need;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ea       = st_q.ea;
    assign ea_valid = st_q.valid;
    assign illegal  = st_q.illegal;
    assign wb_en    = st_q.wb_en;
    assign wb_val   = st_q.wb_val;
    assign ext_cnt  = st_q.cnt;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic [AW-1:0] ea,
    input logic          ea_valid,
    input logic          illegal,
    input logic          wb_en,
    input logic [AW-1:0] wb_val,
    input logic [1:0]    ext_cnt
);
    p_wb_with_valid_r13: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ea_valid);

    p_no_valid_illegal_r11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!ea_valid && !wb_en));

    p_illegal_no_count_r11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (ext_cnt == 2'd0));

    // post-increment: wb - ea is the step; pre-decrement: wb equals ea
    p_wb_delta_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ((wb_val == ea) || ((wb_val - ea) == AW'(1))
                   || ((wb_val - ea) == AW'(2)) || ((wb_val - ea) == AW'(4))));

    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> !busy);

    p_count_range_r8: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (ext_cnt <= 2'd2));

    p_valid_pulse_end_r10: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && busy) |=> 1'b0);
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (st_q.busy),
    .ea       (ea),
    .ea_valid (ea_valid),
    .illegal  (illegal),
    .wb_en    (wb_en),
    .wb_val   (wb_val),
    .ext_cnt  (ext_cnt)
);

// File: tb/ea_unit_tb.sv
`timescale 1ns/1ps
module ea_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] areg = '0;
    logic [2:0]  areg_idx = '0;
    logic [31:0] xreg = '0;
    logic [31:0] pc = '0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic [31:0] ea, wb_val;
    logic        ea_valid, illegal, wb_en;
    logic [1:0]  ext_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ea_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .size(size),
        .areg(areg), .areg_idx(areg_idx), .xreg(xreg), .pc(pc),
        .ext_valid(ext_valid), .ext_word(ext_word), .ea(ea),
        .ea_valid(ea_valid), .illegal(illegal), .wb_en(wb_en),
        .wb_val(wb_val), .ext_cnt(ext_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] nwords(input logic [3:0] m);
        if (m >= 4'd3 && m <= 4'd8) return (m == 4'd6) ? 2'd2 : 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [31:0] stepv(input logic [1:0] sz, input logic [2:0] ai);
        if (sz == 2'd0) return (ai == 3'd7) ? 32'd2 : 32'd1;
        if (sz == 2'd1) return 32'd2;
        return 32'd4;
    endfunction

    function automatic logic [31:0] exp_ea(input logic [3:0] m, input logic [1:0] sz,
        input logic [31:0] a, input logic [2:0] ai, input logic [31:0] x,
        input logic [31:0] p, input logic [15:0] w0, input logic [15:0] w1);
        logic [31:0] s16, s8;
        s16 = {{16{w0[15]}}, w0};
        s8  = {{24{w0[7]}}, w0[7:0]};
        case (m)
            4'd0, 4'd1: return a;
            4'd2: return a - stepv(sz, ai);
            4'd3: return a + s16;
            4'd4: return a + s8 + x;
            4'd5: return s16;
            4'd6: return {w0, w1};
            4'd7: return p + 32'd2 + s16;
            4'd8: return p + 32'd2 + s8 + x;
            default: return 32'd0;
        endcase
    endfunction

    // caller stands at a negedge; returns at the negedge where the result shows
    task automatic run(input logic [3:0] m, input logic [1:0] sz, input logic [31:0] a,
        input logic [2:0] ai, input logic [31:0] x, input logic [31:0] p,
        input logic [15:0] w0, input logic [15:0] w1, input int gap,
        input bit intrude, input string tag);
        logic [1:0] need;
        need = nwords(m);
        mode = m; size = sz; areg = a; areg_idx = ai; xreg = x; pc = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode = $urandom; areg = $urandom;   // fields must have been captured
        if (intrude && need != 2'd0) begin
            start = 1'b1; mode = 4'd0;
            @(negedge clk);
            start = 1'b0;
            check({tag, " R10 start while gathering"}, 32'(ea_valid), 32'd0);
        end
        for (int i = 0; i < int'(need); i++) begin
            repeat (gap) @(negedge clk);
            ext_valid = 1'b1;
            ext_word  = (i == 0) ? w0 : w1;
            @(negedge clk);
            ext_valid = 1'b0;
            ext_word  = $urandom;
        end
        if (m > 4'd8) begin
            check({tag, " R11 illegal"}, 32'(illegal), 32'd1);
            check({tag, " R11 valid"}, 32'(ea_valid), 32'd0);
            check({tag, " R11 wb"}, 32'(wb_en), 32'd0);
            check({tag, " R11 cnt"}, 32'(ext_cnt), 32'd0);
        end else begin
            check({tag, " R10 valid"}, 32'(ea_valid), 32'd1);
            check({tag, " R11 no illegal"}, 32'(illegal), 32'd0);
            check({tag, " ea"}, ea, exp_ea(m, sz, a, ai, x, p, w0, w1));
            check({tag, " R8 cnt"}, 32'(ext_cnt), 32'(need));
            check({tag, " R13 wb_en"}, 32'(wb_en), 32'(m == 4'd1 || m == 4'd2));
            if (m == 4'd1) check({tag, " R3 wb"}, wb_val, a + stepv(sz, ai));
            if (m == 4'd2) check({tag, " R4 wb"}, wb_val, a - stepv(sz, ai));
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", 32'(ea_valid), 32'd0);
        check("R1 reset illegal", 32'(illegal), 32'd0);
        check("R1 reset wb", 32'(wb_en), 32'd0);

        // partial gather then reset
        mode = 4'd6; areg = 32'h0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        ext_valid = 1'b1; ext_word = 16'hDEAD;
        @(negedge clk); ext_valid = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        run(4'd5, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h1234, 16'h0, 0, 0, "R1 after reset");

        @(negedge clk);
        run(4'd0, 2'd2, 32'h1000_0000, 3'd2, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R2");
        @(negedge clk);
        run(4'd1, 2'd0, 32'h0000_2001, 3'd3, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R3 byte");
        run(4'd1, 2'd1, 32'h0000_2000, 3'd3, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R3 word");
        run(4'd1, 2'd2, 32'h0000_2000, 3'd3, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R3 long");
        run(4'd1, 2'd3, 32'h0000_2000, 3'd0, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R3 size3");
        run(4'd2, 2'd0, 32'h0000_3001, 3'd1, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R4 byte");
        run(4'd2, 2'd2, 32'h0000_3000, 3'd1, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R4 long");
        run(4'd1, 2'd0, 32'h0000_4000, 3'd7, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R5 sp inc");
        run(4'd2, 2'd0, 32'h0000_4000, 3'd7, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R5 sp dec");
        run(4'd2, 2'd1, 32'h0000_4000, 3'd7, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R5 sp word");
        @(negedge clk);
        run(4'd3, 2'd0, 32'h0001_0000, 3'd0, 32'h0, 32'h0, 16'h8000, 16'h0, 0, 0, "R6 neg");
        run(4'd3, 2'd0, 32'h0001_0000, 3'd0, 32'h0, 32'h0, 16'h7FFF, 16'h0, 2, 0, "R6 pos");
        run(4'd4, 2'd0, 32'h0001_0000, 3'd0, 32'h0000_0100, 32'h0, 16'h5580, 16'h0, 0, 0, "R7 neg");
        run(4'd4, 2'd0, 32'h0001_0000, 3'd0, 32'hFFFF_FFF0, 32'h0, 16'hAA7F, 16'h0, 1, 0, "R7 pos");
        run(4'd5, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'hFFFE, 16'h0, 0, 0, "R8 short");
        run(4'd6, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h00C0, 16'hFFEE, 0, 0, "R8 long");
        run(4'd6, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h8001, 16'h0002, 3, 0, "R8 long gap");
        run(4'd7, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0000_1000, 16'hFFFC, 16'h0, 0, 0, "R9 pc disp");
        run(4'd8, 2'd0, 32'h0, 3'd0, 32'h0000_0010, 32'h0000_1000, 16'h0104, 16'h0, 0, 0, "R9 pc idx");
        run(4'd3, 2'd0, 32'hFFFF_FFFE, 3'd0, 32'h0, 32'h0, 16'h0004, 16'h0, 0, 0, "R12 wrap up");
        run(4'd2, 2'd2, 32'h0000_0002, 3'd0, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R12 wrap down");
        run(4'd12, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0, 16'h0, 0, 0, "R11 code12");
        run(4'd6, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h1357, 16'h2468, 1, 1, "R10 intrude");

        // stray word while idle
        @(negedge clk);
        ext_valid = 1'b1; ext_word = 16'h7777;
        @(negedge clk);
        ext_valid = 1'b0;
        check("R10 idle word", 32'(ea_valid), 32'd0);
        run(4'd5, 2'd0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0042, 16'h0, 0, 0, "R10 after stray");

        for (int k = 0; k < 300; k++) begin
            logic [3:0] m;
            logic [2:0] ai;
            m  = 4'($urandom % 16);
            if (($urandom % 8) != 0) m = 4'(m % 9);
            ai = ($urandom % 3 == 0) ? 3'd7 : 3'($urandom);
            if ($urandom % 2) @(negedge clk);
            run(m, 2'($urandom), $urandom, ai, $urandom, $urandom, 16'($urandom),
                16'($urandom), int'($urandom % 3), ($urandom % 8) == 0, "rand R12");
        end

        @(negedge clk);
        finish_run();
    end

endmodule